// File: doc/BRIEF.md
# Reconfiguration Cause History Register

This block keeps a short record of why the device abandoned its running application configurations. Five reconfiguration request lines, a 2-bit master state value and a 24-bit boot address feed it. When a commit strobe arrives with at least one request line high, the block forms a 31-bit status word and stores it as the newest entry. The word holds three fields: a one-hot cause, the master state and the address that loaded the configuration being left. The entry that was newest before moves into the older slot on the same clock edge.

A readout port picks the newest or the older entry and loads it into a 31-bit capture register. The captured word is visible in parallel. It can also be shifted out one bit per enable cycle, least significant bit first. If a slot has never been written since reset, a capture of it returns an all-ones marker instead of stale contents.

Top module: `reconf_cause_history`

## Requirements
- R1: Status word layout: bits 30:26 cause, bits 25:24 master state (`mstate_i`), bits 23:0 boot address (`boot_addr_i`). Cause input `cause_req_i[4]` (pin request) maps to bit 30, `[3]` (CRC error) to bit 29, `[2]` (status pin) to bit 28, `[1]` (watchdog timeout) to bit 27, `[0]` (logic request) to bit 26.
- R2: The stored cause field is one-hot. When several request lines are high in a commit cycle, only the highest-numbered one is recorded.
- R3: A commit with any request line high writes the new word into the newest slot and, on the same edge, moves the old newest entry into the older slot.
- R4: A commit with all request lines low leaves both slots and their validity unchanged.
- R5: A capture of the newest slot before the first accepted commit, or of the older slot before the second, yields the marker 31'h7FFF_FFFF.
- R6: With `cap_i` high at an edge, `par_o` shows the selected entry after that edge (`cap_sel_i` 0 = newest, 1 = older). Capture wins over a shift in the same cycle. A capture sees the slots as they stood before a commit in the same cycle.
- R7: With `shift_i` high and `cap_i` low, the capture register shifts right one bit, filling bit 30 with 0. `ser_o` always equals bit 0 of `par_o`, so the word leaves LSB first.
- R8: After reset `par_o` and `ser_o` are 0 and both slots count as unwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| commit_i | input | 1 | Commit strobe for a reconfiguration event |
| cause_req_i | input | 5 | Reconfiguration request lines |
| mstate_i | input | 2 | Master state at the event |
| boot_addr_i | input | 24 | Address of the configuration being left |
| cap_i | input | 1 | Capture the selected entry |
| cap_sel_i | input | 1 | 0 = newest entry, 1 = older entry |
| shift_i | input | 1 | Shift the capture register one bit |
| par_o | output | 31 | Capture register contents |
| ser_o | output | 1 | Serial output, bit 0 of the capture register |

## Verification
The assertions assume that every input is a registered, synchronous level that is stable across each rising edge. They also assume reset is applied at time zero, so that the slots start from a known unwritten state. The bench changes every input only on the falling edge. It holds reset from the first instant and releases it away from a rising edge. It drives commits with request patterns that cover each single line, multi-line ties and the all-low case.

// File: rtl/rch_pkg.sv
package rch_pkg;
    localparam int CAUSE_W = 5;
    localparam int STATE_W = 2;
    localparam int ADDR_W  = 24;
    localparam int WORD_W  = CAUSE_W + STATE_W + ADDR_W;
    localparam logic [WORD_W-1:0] INVALID_MARK = '1;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t newest;
        word_t older;
        logic  newest_ok;
        logic  older_ok;
    } hist_t;
endpackage

// File: rtl/rch_cause_pick.sv
module rch_cause_pick #(
    parameter int W = rch_pkg::CAUSE_W
) (
    input  logic [W-1:0] req_i,
    output logic [W-1:0] pick_o,
    output logic         any_o
);
    always_comb begin
        pick_o = '0;
        for (int i = 0; i < W; i++) begin
            if (req_i[i]) begin
                pick_o    = '0;
                pick_o[i] = 1'b1;
            end
        end
        any_o = |req_i;
    end
endmodule

// File: rtl/rch_store.sv
module rch_store
    import rch_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit_i,
    input  logic [CAUSE_W-1:0] cause_req_i,
    input  logic [STATE_W-1:0] mstate_i,
    input  logic [ADDR_W-1:0]  boot_addr_i,
    output hist_t              hist_o
);
    logic [CAUSE_W-1:0] pick;
    logic               any_req;
    hist_t              hist_d, hist_q;

    rch_cause_pick #(.W(CAUSE_W)) u_pick (
        .req_i  (cause_req_i),
        .pick_o (pick),
        .any_o  (any_req)
    );

    always_comb begin
        hist_d = hist_q;
        if (commit_i && any_req) begin
            hist_d.older     = hist_q.newest;
            hist_d.older_ok  = hist_q.newest_ok;
            hist_d.newest    = {pick, mstate_i, boot_addr_i};
            hist_d.newest_ok = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

    assign hist_o = hist_q;
endmodule

// File: rtl/rch_readout.sv
module rch_readout
    import rch_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  hist_t hist_i,
    input  logic  cap_i,
    input  logic  cap_sel_i,
    input  logic  shift_i,
    output word_t par_o,
    output logic  ser_o
);
    word_t sreg_d, sreg_q;
    word_t load_word;

    always_comb begin
        if (cap_sel_i) begin
            load_word = hist_i.older_ok ? hist_i.older : INVALID_MARK;
        end else begin
            load_word = hist_i.newest_ok ? hist_i.newest : INVALID_MARK;
        end
        sreg_d = sreg_q;
        if (cap_i) begin
            sreg_d = load_word;
        end else if (shift_i) begin
            sreg_d = {1'b0, sreg_q[WORD_W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
        end else begin
            sreg_q <= sreg_d;
        end
    end

    assign par_o = sreg_q;
    assign ser_o = sreg_q[0];
endmodule

// File: rtl/reconf_cause_history.sv
module reconf_cause_history
    import rch_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                commit_i,
    input  logic [CAUSE_W-1:0]  cause_req_i,
    input  logic [STATE_W-1:0]  mstate_i,
    input  logic [ADDR_W-1:0]   boot_addr_i,
    input  logic                cap_i,
    input  logic                cap_sel_i,
    input  logic                shift_i,
    output logic [WORD_W-1:0]   par_o,
    output logic                ser_o
);
    hist_t hist;

    rch_store u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit_i    (commit_i),
        .cause_req_i (cause_req_i),
        .mstate_i    (mstate_i),
        .boot_addr_i (boot_addr_i),
        .hist_o      (hist)
    );

    rch_readout u_read (
        .clk       (clk),
        .rst_n     (rst_n),
        .hist_i    (hist),
        .cap_i     (cap_i),
        .cap_sel_i (cap_sel_i),
        .shift_i   (shift_i),
        .par_o     (par_o),
        .ser_o     (ser_o)
    );
endmodule

// File: rtl/rch_checker.sv
module rch_checker
    import rch_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               commit_i,
    input logic [CAUSE_W-1:0] cause_req_i,
    input logic               cap_i,
    input logic               cap_sel_i,
    input logic               shift_i,
    input logic [WORD_W-1:0]  par_o,
    input hist_t              hist
);
    localparam int CHI = WORD_W - 1;
    localparam int CLO = WORD_W - CAUSE_W;

    p_onehot_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hist.newest_ok |-> $onehot(hist.newest[CHI:CLO]));

    p_top_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && cause_req_i[CAUSE_W-1]) |=> hist.newest[CHI]);

    p_age_move_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && (|cause_req_i)) |=> (hist.older == $past(hist.newest)));

    p_ignore_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && !(|cause_req_i)) |=> ($stable(hist.newest) && $stable(hist.older)
                                           && $stable(hist.newest_ok) && $stable(hist.older_ok)));

    p_marker_newest_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_i && !cap_sel_i && !hist.newest_ok) |=> (par_o == INVALID_MARK));

    p_marker_older_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_i && cap_sel_i && !hist.older_ok) |=> (par_o == INVALID_MARK));

    p_shift_right_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !cap_i) |=> (par_o == {1'b0, $past(par_o[WORD_W-1:1])}));
endmodule

bind reconf_cause_history rch_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit_i    (commit_i),
    .cause_req_i (cause_req_i),
    .cap_i       (cap_i),
    .cap_sel_i   (cap_sel_i),
    .shift_i     (shift_i),
    .par_o       (par_o),
    .hist        (hist)
);

// File: tb/tb_reconf_cause_history.sv
module tb_reconf_cause_history;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        commit_i = 1'b0;
    logic [4:0]  cause_req_i = '0;
    logic [1:0]  mstate_i = '0;
    logic [23:0] boot_addr_i = '0;
    logic        cap_i = 1'b0;
    logic        cap_sel_i = 1'b0;
    logic        shift_i = 1'b0;
    logic [30:0] par_o;
    logic        ser_o;

    int n_chk = 0;
    int n_bad = 0;

    logic [30:0] m_new, m_old;
    logic        m_new_ok = 1'b0, m_old_ok = 1'b0;

    logic [30:0] exp_q[$];
    string       tag_q[$];

    localparam logic [30:0] MARK = 31'h7FFF_FFFF;

    always #10 clk = ~clk;

    reconf_cause_history dut (
        .clk(clk), .rst_n(rst_n), .commit_i(commit_i), .cause_req_i(cause_req_i),
        .mstate_i(mstate_i), .boot_addr_i(boot_addr_i), .cap_i(cap_i),
        .cap_sel_i(cap_sel_i), .shift_i(shift_i), .par_o(par_o), .ser_o(ser_o)
    );

    task automatic check(input string tag, input logic [30:0] act, input logic [30:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] pick(input logic [4:0] c);
        logic [4:0] r = '0;
        for (int i = 4; i >= 0; i--) begin
            if (c[i]) begin
                r[i] = 1'b1;
                break;
            end
        end
        return r;
    endfunction

    task automatic do_commit(input logic [4:0] c, input logic [1:0] st, input logic [23:0] a);
        @(negedge clk);
        commit_i = 1'b1; cause_req_i = c; mstate_i = st; boot_addr_i = a;
        if (c != 0) begin
            m_old = m_new; m_old_ok = m_new_ok;
            m_new = {pick(c), st, a}; m_new_ok = 1'b1;
        end
        @(negedge clk);
        commit_i = 1'b0; cause_req_i = '0;
    endtask

    task automatic do_capture(input logic sel, input logic sh, input string tag);
        logic [30:0] e;
        @(negedge clk);
        if (sel) e = m_old_ok ? m_old : MARK;
        else     e = m_new_ok ? m_new : MARK;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        cap_i = 1'b1; cap_sel_i = sel; shift_i = sh;
        @(negedge clk);
        cap_i = 1'b0; shift_i = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    // monitor: pops the expected word after each capture edge
    initial begin
        forever begin
            @(posedge clk);
            if (cap_i && rst_n) begin
                @(negedge clk);
                check(tag_q.pop_front(), par_o, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [30:0] w;
        m_new = '0; m_old = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 reset par_o", par_o, 31'd0);
        check("R8 reset ser_o", {30'd0, ser_o}, 31'd0);

        do_capture(1'b0, 1'b0, "R5 newest unwritten");
        do_capture(1'b1, 1'b0, "R5 older unwritten");

        do_commit(5'b10001, 2'b10, 24'hABCDEF);
        do_capture(1'b0, 1'b0, "R2 R1 pin beats logic request");
        do_capture(1'b1, 1'b0, "R5 older before second commit");

        do_commit(5'b00000, 2'b11, 24'h123456);
        do_capture(1'b0, 1'b0, "R4 empty commit ignored newest");
        do_capture(1'b1, 1'b0, "R4 empty commit ignored older");

        do_commit(5'b01100, 2'b01, 24'h00F00D);
        do_capture(1'b0, 1'b0, "R2 CRC beats status pin");
        do_capture(1'b1, 1'b0, "R3 newest aged into older");

        for (int i = 0; i < 5; i++) begin
            do_commit(5'b1 << i, i[1:0], 24'h100000 + 24'(i));
            do_capture(1'b0, 1'b0, $sformatf("R1 single cause %0d newest", i));
            do_capture(1'b1, 1'b0, $sformatf("R3 single cause %0d older", i));
        end

        do_commit(5'b00110, 2'b00, 24'hFFFFFF);
        do_capture(1'b0, 1'b1, "R6 capture wins over shift");

        // R6: capture in the same cycle as a commit sees the pre-commit slots
        @(negedge clk);
        w = m_new_ok ? m_new : MARK;
        exp_q.push_back(w);
        tag_q.push_back("R6 capture sees pre-commit slot");
        cap_i = 1'b1; cap_sel_i = 1'b0;
        commit_i = 1'b1; cause_req_i = 5'b00010; mstate_i = 2'b11; boot_addr_i = 24'h5A5A5A;
        m_old = m_new; m_new = {5'b00010, 2'b11, 24'h5A5A5A};
        @(negedge clk);
        cap_i = 1'b0; commit_i = 1'b0; cause_req_i = '0;
        while (exp_q.size() != 0) @(negedge clk);
        do_capture(1'b0, 1'b0, "R6 newest after same-cycle commit");

        // R7 serial readout LSB first
        do_capture(1'b1, 1'b0, "R6 older select");
        w = m_old;
        for (int b = 0; b < 31; b++) begin
            check($sformatf("R7 serial bit %0d", b), {30'd0, ser_o}, {30'd0, w[b]});
            @(negedge clk);
            shift_i = 1'b1;
            @(negedge clk);
            shift_i = 1'b0;
        end
        check("R7 register empty after full shift", par_o, 31'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule